// File: doc/BRIEF.md
# Ternary Polynomial Multiplier

This block computes cyclic polynomial products for a lattice-based public-key scheme, one output coefficient at a time. Each product term multiplies a 7-bit coefficient by a ternary coefficient (-1, 0 or +1). Because the ternary operand only selects between add, subtract and hold, the multiplier is an accumulator and never needs a real multiplier array. The products are taken modulo x^N - 1, so output coefficient k is the sum over j of a_j * b_((k-j) mod N). All arithmetic wraps modulo 128.

One core serves three operations, selected when a run starts. In the encrypt operation, a ternary blinding polynomial is first streamed into a ternary ring register. The block then multiplies it by the public-key table and adds one ternary message coefficient to each output. In the first decrypt pass, a 7-bit ciphertext polynomial is streamed into a 7-bit rotating register and multiplied by the ternary private-key table. Each sum is reduced modulo 3 by a bit-serial reducer, and the ternary result is shifted into the ternary ring. In the second decrypt pass, that stored ternary polynomial is multiplied by the inverse-key table and reduced modulo 3 again, and the recovered plaintext goes to the result register.

The key tables are outside the block. The block presents a table index, and the table returns the coefficient combinationally in the same cycle. Input coefficients are requested in ascending index order. Results are also produced in ascending index order, and each one is marked by a one-cycle `done` pulse.

Top module: `tern_poly_mul`

## Requirements
- R1: After reset, `busy`, `done`, `ld_req` and `msg_req` are 0 and `result` is 0.
- R2: Ternary codes are 2'b00 = 0, 2'b01 = +1 and 2'b11 = -1. The code 2'b10 acts as 0. Every sum wraps modulo 128.
- R3: Mode 2'b00 (encrypt) streams the blinding trits r in over `trit_in`. It then outputs result_k = (sum_j pub_j * r_((k-j) mod N) + msg_k) mod 128, where pub_j is `pub_key` at `tab_idx` = j.
- R4: Mode 2'b01 (decrypt pass one) streams ciphertext e in over `coef_in` and stores a_k = mod3(centre(sum_j priv_j * e_((k-j) mod N))). A following mode 2'b10 run (decrypt pass two) outputs mod3(centre(sum_j inv_j * a_((k-j) mod N))).
- R5: Results appear with `res_idx` = 0, 1, ..., N-1 in that order. Each is marked by a `done` pulse lasting exactly one cycle, and every encrypt or pass-two run gives N pulses.
- R6: In encrypt, the first `done` comes 2N+2 clock edges after the edge that accepts `start`. Each later `done` follows the previous one by N+2 edges.
- R7: In pass two, the first `done` comes N+11 edges after acceptance, and each later one follows by N+11 edges. Of these, the modulo-3 reduction of the 7-bit sum takes 7+3 = 10 cycles.
- R8: Reduction treats the 7-bit sum as a centred value in -64..63 and maps it to -1, 0 or +1 congruent modulo 3. A pass-two result of +1 is output as 7'd1, -1 as 7'd127 and 0 as 7'd0. For example, sum 64 (-64) gives -1 and sum 63 gives 0.
- R9: A `start` pulse while `busy` is 1 is ignored. A change of `mode` after acceptance has no effect on the run.
- R10: Encrypt and pass one raise `ld_req` for exactly N cycles, with `in_idx` counting 0..N-1. Encrypt raises `msg_req` once per output, with `in_idx` = k. Pass two raises neither.
- R11: Pass one produces no `done` pulse.
- R12: A `start` with `mode` = 2'b11 is ignored, and `busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (sampled when idle) |
| mode | input | 2 | 00 encrypt, 01 decrypt pass one, 10 decrypt pass two |
| coef_in | input | 7 | Ciphertext coefficient during pass-one loading |
| trit_in | input | 2 | Blinding trit during encrypt loading |
| msg_in | input | 2 | Message trit when `msg_req` is high |
| pub_key | input | 7 | Public-key table value at `tab_idx` |
| priv_trit | input | 2 | Private-key table trit at `tab_idx` |
| inv_key | input | 7 | Inverse-key table value at `tab_idx` |
| tab_idx | output | 8 | Key table index j during accumulation |
| in_idx | output | 8 | Index of the coefficient requested on `coef_in`/`trit_in`/`msg_in` |
| ld_req | output | 1 | A load coefficient is taken at the next edge |
| msg_req | output | 1 | A message trit is taken at the next edge |
| busy | output | 1 | A run is in progress |
| result | output | 7 | Last written result coefficient |
| res_idx | output | 8 | Index of `result` |
| done | output | 1 | One-cycle pulse: `result` was just written |

## Verification
The assertions assume the following about the inputs:
- The key tables answer combinationally for the index shown on `tab_idx`, so the operand is valid in the same cycle.
- Input coefficients are present in every cycle that `ld_req` or `msg_req` is high.
- The reducer is only started when idle; this is checked by an assertion inside the reducer.

The bench drives all data inputs at the falling edge, using the `in_idx` and `tab_idx` shown in that cycle and looking them up in its own arrays. Within a run it raises `start` only once, deliberately, to exercise R9. The sums it chooses include values that wrap and the centred extremes -64 and 63.

// File: rtl/tpm_pkg.sv
package tpm_pkg;

    typedef enum logic [1:0] {
        MD_ENC  = 2'b00,
        MD_DEC1 = 2'b01,
        MD_DEC2 = 2'b10
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_MUL,
        ST_ADD,
        ST_RED,
        ST_FIN
    } state_e;

    typedef enum logic [1:0] {
        RING_HOLD,
        RING_SHIFT,
        RING_ROTR,
        RING_ROTL
    } ring_op_e;

    localparam logic [1:0] TRIT_ZERO = 2'b00;
    localparam logic [1:0] TRIT_POS  = 2'b01;
    localparam logic [1:0] TRIT_NEG  = 2'b11;

endpackage

// File: rtl/tpm_ring.sv
module tpm_ring
    import tpm_pkg::*;
#(
    parameter int N = 11,
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  ring_op_e     op,
    input  logic [W-1:0] din,
    output logic [W-1:0] head
);

    logic [W-1:0] cell_q [N];
    logic [W-1:0] cell_d [N];

    for (genvar i = 0; i < N; i++) begin : g_cell
        localparam int UP = (i + 1) % N;
        localparam int DN = (i + N - 1) % N;
        always_comb begin
            case (op)
                RING_SHIFT: cell_d[i] = (i == N - 1) ? din : cell_q[UP];
                RING_ROTR:  cell_d[i] = cell_q[DN];
                RING_ROTL:  cell_d[i] = cell_q[UP];
                default:    cell_d[i] = cell_q[i];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cell_q <= '{default: '0};
        else        cell_q <= cell_d;
    end

    assign head = cell_q[0];

    // R10
    hold_keeps_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == RING_HOLD) |=> $stable(head));

endmodule

// File: rtl/tpm_mac.sv
module tpm_mac
    import tpm_pkg::*;
#(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en_mul,
    input  logic          en_add,
    input  logic [CW-1:0] opnd,
    input  logic [1:0]    trit,
    input  logic [1:0]    msg,
    output logic [CW-1:0] acc
);

    logic [CW-1:0] acc_d, acc_q;
    logic [1:0]    sel;
    logic [CW-1:0] addend;

    always_comb begin
        sel    = en_add ? msg : trit;
        addend = en_add ? CW'(1) : opnd;
        acc_d  = acc_q;
        if (clr) begin
            acc_d = '0;
        end else if (en_mul || en_add) begin
            case (sel)
                TRIT_POS: acc_d = acc_q + addend;
                TRIT_NEG: acc_d = acc_q - addend;
                default:  acc_d = acc_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign acc = acc_q;

    // R2
    single_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_mul && en_add) && !(clr && (en_mul || en_add)));

endmodule

// File: rtl/tpm_mod3.sv
module tpm_mod3
    import tpm_pkg::*;
#(
    parameter int VW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [VW-1:0] val,
    output logic          busy,
    output logic [1:0]    trit
);

    localparam int STEPS = VW + 3;
    localparam int PW    = $clog2(STEPS);
    localparam logic [PW-1:0] PH_LAST_BIT = PW'(VW);
    localparam logic [PW-1:0] PH_SIGN     = PW'(VW + 1);

    typedef struct packed {
        logic [PW-1:0] phase;
        logic [VW-1:0] mag;
        logic [1:0]    rem;
        logic          neg;
        logic [1:0]    trit;
    } red_t;

    red_t s_d, s_q;
    logic [2:0] dbl;

    always_comb begin
        s_d = s_q;
        dbl = {s_q.rem, 1'b0} + {2'b00, s_q.mag[VW-1]};
        if (s_q.phase == '0) begin
            if (start) begin
                s_d.neg   = val[VW-1];
                s_d.mag   = val[VW-1] ? (~val + 1'b1) : val;
                s_d.rem   = 2'd0;
                s_d.phase = PW'(1);
            end
        end else if (s_q.phase <= PH_LAST_BIT) begin
            s_d.rem   = (dbl >= 3'd3) ? 2'(dbl - 3'd3) : dbl[1:0];
            s_d.mag   = s_q.mag << 1;
            s_d.phase = s_q.phase + 1'b1;
        end else if (s_q.phase == PH_SIGN) begin
            if (s_q.neg && s_q.rem != 2'd0) s_d.rem = 2'd3 - s_q.rem;
            s_d.phase = s_q.phase + 1'b1;
        end else begin
            case (s_q.rem)
                2'd0:    s_d.trit = TRIT_ZERO;
                2'd1:    s_d.trit = TRIT_POS;
                default: s_d.trit = TRIT_NEG;
            endcase
            s_d.phase = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = (s_q.phase != '0);
    assign trit = s_q.trit;

    // R7
    start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

    // R8
    trit_code_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trit != 2'b10);

endmodule

// File: rtl/tern_poly_mul.sv
module tern_poly_mul
    import tpm_pkg::*;
#(
    parameter int N  = 11,
    parameter int CW = 7,
    parameter int IW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    mode,
    input  logic [CW-1:0] coef_in,
    input  logic [1:0]    trit_in,
    input  logic [1:0]    msg_in,
    input  logic [CW-1:0] pub_key,
    input  logic [1:0]    priv_trit,
    input  logic [CW-1:0] inv_key,
    output logic [IW-1:0] tab_idx,
    output logic [IW-1:0] in_idx,
    output logic          ld_req,
    output logic          msg_req,
    output logic          busy,
    output logic [CW-1:0] result,
    output logic [IW-1:0] res_idx,
    output logic          done
);

    localparam int RED_CYC = CW + 3;
    localparam int RW      = $clog2(RED_CYC);
    localparam logic [IW-1:0] LAST    = IW'(N - 1);
    localparam logic [RW-1:0] RED_END = RW'(RED_CYC - 1);

    typedef struct packed {
        state_e        st;
        mode_e         md;
        logic [IW-1:0] k;
        logic [IW-1:0] j;
        logic [RW-1:0] red;
        logic [CW-1:0] res;
        logic [IW-1:0] ridx;
        logic          done;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [CW-1:0] acc, opnd, rr_head;
    logic [1:0]    n2_head, trit_op, n2_din, red_trit;
    ring_op_e      n2_op, rr_op;
    logic          mac_clr, en_mul, en_add, red_start, red_busy;

    // control sequencer
    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        case (c_q.st)
            ST_IDLE: begin
                if (start && mode != 2'b11) begin
                    c_d.md = mode_e'(mode);
                    c_d.j  = '0;
                    c_d.k  = '0;
                    c_d.st = (mode == MD_DEC2) ? ST_MUL : ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (c_q.j == LAST) begin
                    c_d.j  = '0;
                    c_d.st = ST_MUL;
                end else begin
                    c_d.j = c_q.j + 1'b1;
                end
            end
            ST_MUL: begin
                if (c_q.j == LAST) begin
                    c_d.j   = '0;
                    c_d.red = '0;
                    c_d.st  = (c_q.md == MD_ENC) ? ST_ADD : ST_RED;
                end else begin
                    c_d.j = c_q.j + 1'b1;
                end
            end
            ST_ADD: c_d.st = ST_FIN;
            ST_RED: begin
                if (c_q.red == RED_END) c_d.st = ST_FIN;
                else                    c_d.red = c_q.red + 1'b1;
            end
            ST_FIN: begin
                if (c_q.md != MD_DEC1) begin
                    c_d.done = 1'b1;
                    c_d.ridx = c_q.k;
                    if (c_q.md == MD_ENC) begin
                        c_d.res = acc;
                    end else begin
                        case (red_trit)
                            TRIT_POS: c_d.res = CW'(1);
                            TRIT_NEG: c_d.res = '1;
                            default:  c_d.res = '0;
                        endcase
                    end
                end
                if (c_q.k == LAST) begin
                    c_d.st = ST_IDLE;
                end else begin
                    c_d.k  = c_q.k + 1'b1;
                    c_d.st = ST_MUL;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
            c_q.md <= MD_ENC;
        end else begin
            c_q <= c_d;
        end
    end

    // operand routing per mode
    always_comb begin
        case (c_q.md)
            MD_ENC:  opnd = pub_key;
            MD_DEC1: opnd = rr_head;
            default: opnd = inv_key;
        endcase
        trit_op   = (c_q.md == MD_DEC1) ? priv_trit : n2_head;
        n2_op     = RING_HOLD;
        rr_op     = RING_HOLD;
        n2_din    = trit_in;
        case (c_q.st)
            ST_LOAD: begin
                if (c_q.md == MD_ENC)  n2_op = RING_SHIFT;
                if (c_q.md == MD_DEC1) rr_op = RING_SHIFT;
            end
            ST_MUL: begin
                if (c_q.md == MD_DEC1) rr_op = RING_ROTR;
                else                   n2_op = RING_ROTR;
            end
            ST_FIN: begin
                if (c_q.md == MD_DEC1) begin
                    rr_op  = RING_ROTL;
                    n2_op  = RING_SHIFT;
                    n2_din = red_trit;
                end else begin
                    n2_op = RING_ROTL;
                end
            end
            default: ;
        endcase
        mac_clr   = (c_q.st == ST_IDLE) || (c_q.st == ST_FIN);
        en_mul    = (c_q.st == ST_MUL);
        en_add    = (c_q.st == ST_ADD);
        red_start = (c_q.st == ST_RED) && (c_q.red == '0);
    end

    tpm_ring #(.N(N), .W(2)) u_tern_ring (
        .clk(clk), .rst_n(rst_n), .op(n2_op), .din(n2_din), .head(n2_head)
    );

    tpm_ring #(.N(N), .W(CW)) u_coef_ring (
        .clk(clk), .rst_n(rst_n), .op(rr_op), .din(coef_in), .head(rr_head)
    );

    tpm_mac #(.CW(CW)) u_mac (
        .clk(clk), .rst_n(rst_n), .clr(mac_clr), .en_mul(en_mul), .en_add(en_add),
        .opnd(opnd), .trit(trit_op), .msg(msg_in), .acc(acc)
    );

    tpm_mod3 #(.VW(CW)) u_mod3 (
        .clk(clk), .rst_n(rst_n), .start(red_start), .val(acc),
        .busy(red_busy), .trit(red_trit)
    );

    assign tab_idx = c_q.j;
    assign in_idx  = (c_q.st == ST_LOAD) ? c_q.j : c_q.k;
    assign ld_req  = (c_q.st == ST_LOAD);
    assign msg_req = (c_q.st == ST_ADD);
    assign busy    = (c_q.st != ST_IDLE);
    assign result  = c_q.res;
    assign res_idx = c_q.ridx;
    assign done    = c_q.done;

    // R11
    no_done_pass_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (c_q.md != MD_DEC1));

    // R10
    req_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_req && msg_req));

    // R10
    tab_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tab_idx < IW'(N));

    // R7
    reducer_finished_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_FIN && c_q.md != MD_ENC) |-> !red_busy);

    // R9
    mode_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st != ST_IDLE) |=> $stable(c_q.md));

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/sim_tern_poly_mul.sv
module sim_tern_poly_mul;

    localparam int CLK_PERIOD = 10;
    localparam int N = 11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [6:0] coef_in = '0;
    logic [1:0] trit_in = '0;
    logic [1:0] msg_in = '0;
    logic [6:0] pub_key, inv_key;
    logic [1:0] priv_trit;
    logic [7:0] tab_idx, in_idx, res_idx;
    logic       ld_req, msg_req, busy, done;
    logic [6:0] result;

    logic [6:0] h_a [N];
    logic [6:0] fp_a[N];
    logic [6:0] e_a [N];
    logic [1:0] f_a [N];
    logic [1:0] r_a [N];
    logic [1:0] m_a [N];
    int         exp_a[N];
    int         a_t [N];

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int unsigned seed = 32'h1234_5678;

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign pub_key   = (int'(tab_idx) < N) ? h_a[tab_idx]  : '0;
    assign priv_trit = (int'(tab_idx) < N) ? f_a[tab_idx]  : '0;
    assign inv_key   = (int'(tab_idx) < N) ? fp_a[tab_idx] : '0;

    tern_poly_mul #(.N(N), .CW(7), .IW(8)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .coef_in(coef_in), .trit_in(trit_in), .msg_in(msg_in),
        .pub_key(pub_key), .priv_trit(priv_trit), .inv_key(inv_key),
        .tab_idx(tab_idx), .in_idx(in_idx), .ld_req(ld_req), .msg_req(msg_req),
        .busy(busy), .result(result), .res_idx(res_idx), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    function automatic int unsigned rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed >> 8;
    endfunction

    function automatic logic [1:0] rtrit();
        case (rnd() % 3)
            0:       return 2'b00;
            1:       return 2'b01;
            default: return 2'b11;
        endcase
    endfunction

    function automatic int tv(input logic [1:0] c);
        if (c == 2'b01) return 1;
        if (c == 2'b11) return -1;
        return 0;
    endfunction

    function automatic int wrap7(input int s);
        int x = s % 128;
        if (x < 0) x += 128;
        return x;
    endfunction

    function automatic int cent(input int u);
        return (u > 63) ? u - 128 : u;
    endfunction

    function automatic int mod3c(input int v);
        int x = v % 3;
        if (x < 0) x += 3;
        return (x == 2) ? -1 : x;
    endfunction

    function automatic int t2c(input int t);
        if (t == 1) return 1;
        if (t == -1) return 127;
        return 0;
    endfunction

    task automatic model_enc();
        for (int k = 0; k < N; k++) begin
            int s = 0;
            for (int j = 0; j < N; j++) s += int'(h_a[j]) * tv(r_a[(k - j + N) % N]);
            exp_a[k] = wrap7(s + tv(m_a[k]));
        end
    endtask

    task automatic model_dec();
        for (int k = 0; k < N; k++) begin
            int s = 0;
            for (int j = 0; j < N; j++) s += tv(f_a[j]) * int'(e_a[(k - j + N) % N]);
            a_t[k] = mod3c(cent(wrap7(s)));
        end
        for (int k = 0; k < N; k++) begin
            int s = 0;
            for (int j = 0; j < N; j++) s += int'(fp_a[j]) * a_t[(k - j + N) % N];
            exp_a[k] = t2c(mod3c(cent(wrap7(s))));
        end
    endtask

    // Runs one operation, feeds the requested inputs and checks every output.
    task automatic run_op(input logic [1:0] md, input int exp_first, input int exp_gap,
                          input int exp_done, input int exp_ld, input int exp_msg,
                          input bit poke, input string req);
        int t0, tlast, nd, nld, nmsg;
        nd = 0; nld = 0; nmsg = 0; tlast = 0;
        @(negedge clk);
        start = 1'b1;
        mode  = md;
        t0    = cyc;
        for (int w = 0; w < 5000; w++) begin
            @(negedge clk);
            start = (poke && w == 5);
            if (poke && w == 5) mode = 2'b10;
            if (ld_req) begin
                // R10 load order
                chk(int'(in_idx) == nld, "R10", "load index", int'(in_idx), nld);
                coef_in = e_a[in_idx % N];
                trit_in = r_a[in_idx % N];
                nld++;
            end
            if (msg_req) begin
                chk(int'(in_idx) == nmsg, "R10", "message index", int'(in_idx), nmsg);
                msg_in = m_a[in_idx % N];
                nmsg++;
            end
            if (done) begin
                chk(int'(res_idx) == nd, "R5", "result order", int'(res_idx), nd);
                chk(int'(result) == exp_a[res_idx % N], req, "result value",
                    int'(result), exp_a[res_idx % N]);
                if (nd == 0)
                    chk(cyc - t0 == exp_first, (md == 2'b00) ? "R6" : "R7",
                        "first result latency", cyc - t0, exp_first);
                else
                    chk(cyc - tlast == exp_gap, (md == 2'b00) ? "R6" : "R7",
                        "result spacing", cyc - tlast, exp_gap);
                tlast = cyc;
                nd++;
            end
            if (!busy) break;
        end
        chk(nd == exp_done, (md == 2'b01) ? "R11" : "R5", "done pulses", nd, exp_done);
        chk(nld == exp_ld, "R10", "load cycles", nld, exp_ld);
        chk(nmsg == exp_msg, "R10", "message cycles", nmsg, exp_msg);
    endtask

    task automatic t_reset();
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1", "busy", int'(busy), 0);
        chk(done == 1'b0, "R1", "done", int'(done), 0);
        chk(ld_req == 1'b0 && msg_req == 1'b0, "R1", "requests", int'(ld_req), 0);
        chk(result == '0, "R1", "result", int'(result), 0);
    endtask

    task automatic t_enc_basic();
        for (int i = 0; i < N; i++) begin
            h_a[i] = 7'(rnd());
            r_a[i] = rtrit();
            m_a[i] = rtrit();
        end
        model_enc();
        run_op(2'b00, 2 * N + 3, N + 2, N, N, N, 1'b0, "R3");
    endtask

    task automatic t_enc_wrap();
        // R2: large coefficients wrap, code 2'b10 acts as zero
        for (int i = 0; i < N; i++) begin
            h_a[i] = 7'd127;
            r_a[i] = (i == 3) ? 2'b10 : ((i % 4 == 1) ? 2'b11 : 2'b01);
            m_a[i] = (i % 2 == 0) ? 2'b01 : 2'b10;
        end
        model_enc();
        run_op(2'b00, 2 * N + 3, N + 2, N, N, N, 1'b0, "R2");
    endtask

    task automatic t_enc_poke();
        // R9: start and mode change during a run are ignored
        for (int i = 0; i < N; i++) begin
            h_a[i] = 7'(rnd());
            r_a[i] = rtrit();
            m_a[i] = rtrit();
        end
        model_enc();
        run_op(2'b00, 2 * N + 3, N + 2, N, N, N, 1'b1, "R9");
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R9", "idle after run", int'(busy), 0);
    endtask

    task automatic t_dec_reduce();
        // R8: identity keys expose mod3 of the centred ciphertext
        logic [6:0] vals [11] = '{7'd64, 7'd63, 7'd0, 7'd127, 7'd65, 7'd1,
                                  7'd2, 7'd3, 7'd66, 7'd100, 7'd30};
        for (int i = 0; i < N; i++) begin
            e_a[i]  = (i < 11) ? vals[i] : 7'(i);
            f_a[i]  = (i == 0) ? 2'b01 : 2'b00;
            fp_a[i] = (i == 0) ? 7'd1 : 7'd0;
        end
        model_dec();
        run_op(2'b01, 0, 0, 0, N, 0, 1'b0, "R11");
        run_op(2'b10, N + 12, N + 11, N, 0, 0, 1'b0, "R8");
    endtask

    task automatic t_dec_full();
        for (int i = 0; i < N; i++) begin
            e_a[i]  = 7'(rnd());
            f_a[i]  = rtrit();
            fp_a[i] = 7'(rnd());
        end
        model_dec();
        run_op(2'b01, 0, 0, 0, N, 0, 1'b0, "R4");
        run_op(2'b10, N + 12, N + 11, N, 0, 0, 1'b0, "R4");
    endtask

    task automatic t_bad_mode();
        @(negedge clk);
        start = 1'b1;
        mode  = 2'b11;
        @(negedge clk);
        start = 1'b0;
        for (int w = 0; w < 3; w++) begin
            // R12 reserved mode
            chk(busy == 1'b0 && ld_req == 1'b0, "R12", "reserved mode idle", int'(busy), 0);
            chk(done == 1'b0, "R12", "reserved mode done", int'(done), 0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R5 act=%0d exp=finished", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            h_a[i] = '0; fp_a[i] = '0; e_a[i] = '0;
            f_a[i] = '0; r_a[i] = '0; m_a[i] = '0;
            exp_a[i] = 0; a_t[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enc_basic();
        t_enc_wrap();
        t_enc_poke();
        t_dec_reduce();
        t_dec_full();
        t_bad_mode();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule